// File: doc/BRIEF.md
# UART Transmit and Receive FIFO Pair

This block sits between a UART's serial engine and the CPU-facing register logic. It buffers outgoing bytes in a transmit queue of 8-bit entries and incoming characters in a receive queue of 12-bit entries. Each receive entry is 8 data bits with 4 line-error bits above them, and each queue holds up to four entries. A single mode input chooses between four-deep queue operation and a one-entry holding register per direction. Out of reset the block is in holding-register mode.

The CPU side writes transmit bytes, reads receive entries, sets the mode, loads the two threshold codes and clears the sticky receive overrun flag. The line side pops bytes for the transmitter and pushes received entries. Both queues present their oldest entry on the output at all times. The block reports empty and full for both directions, a receive overrun flag, and one level-sensitive interrupt request per direction. Each request is asserted whenever its queue's fill count satisfies its own programmable threshold.

Top module: `uart_fifo_pair`

## Requirements
- R1: With `fifo_en` high, each queue holds up to 4 entries and returns them oldest first. `*_full` is high at 4 entries and `*_empty` is high at 0.
- R2: A receive entry is stored and returned as all 12 bits, with data in bits 7:0 and error flags in bits 11:8.
- R3: After reset, both queues are empty, the mode is holding-register, `rx_ovr` is 0, and both threshold codes are 3'd1 (the 1/2 level).
- R4: With `fifo_en` low, each direction holds at most 1 entry. Full means 1 entry is held and empty means 0. `rx_irq` is high while the holding register is occupied, and `tx_irq` is high while it is vacant.
- R5: A receive push while the queue is full and no read happens in the same cycle discards the oldest entry, appends the new one, keeps the queue full and sets `rx_ovr`.
- R6: A transmit write while the queue is full is dropped, leaving contents and count unchanged, and produces no indication. A pop in the same cycle does not make room for that write.
- R7: `rx_ovr` stays high until a cycle with `rx_ovr_clr` high and no new overrun. If an overrun and a clear fall in the same cycle, the flag stays set.
- R8: A change of `fifo_en` empties both queues on the next clock edge. Pushes, writes, pops and reads in that cycle are ignored, and `rx_ovr` is not affected by the change.
- R9: In queue mode, `rx_irq` is high while the receive count is at least the threshold level. The `rx_thr_in` codes 0, 1, 2 and 3 select levels 1, 2, 3 and 4 (1/4, 1/2, 3/4 and full).
- R10: In queue mode, `tx_irq` is high while the transmit count is at most the threshold level. The `tx_thr_in` codes 0, 1, 2 and 3 select levels 3, 2, 1 and 0 (3/4, 1/2, 1/4 and empty).
- R11: Both threshold codes are loaded when `thr_we` is high and are held otherwise. Codes 4 to 7 act as the 1/2 level.
- R12: A pop of an empty transmit queue and a read of an empty receive queue have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects four-deep queues, 0 selects holding registers |
| tx_thr_in | input | 3 | Transmit threshold code, loaded on `thr_we` |
| rx_thr_in | input | 3 | Receive threshold code, loaded on `thr_we` |
| thr_we | input | 1 | Loads both threshold codes |
| tx_wr | input | 1 | CPU write strobe for the transmit queue |
| tx_wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_irq | output | 1 | Transmit threshold request |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Receiver delivers an entry |
| rx_push_data | input | 12 | Received entry: error flags 11:8, data 7:0 |
| rx_rd | input | 1 | CPU read strobe, removes the oldest entry |
| rx_rd_data | output | 12 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| rx_ovr_clr | input | 1 | Clears `rx_ovr` |
| rx_irq | output | 1 | Receive threshold request |

## Verification
Every operation is registered on one clock edge. Its effect on flags, head data, overrun and interrupt requests is visible in the cycle after the stimulus and is not delayed further. The bench drives inputs on the falling edge and holds them for exactly one rising edge. A queue-based model then updates on that rising edge from the same inputs, and all outputs are compared against the model on the next falling edge. Because of this ordering, each comparison lands exactly one edge after its cause, including the flush edge after a mode change and the first edge after a threshold load. Directed checks sample at those same points.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef logic [2:0] thr_code_t;

  // Both directions come out of reset at the half-full setting.
  localparam thr_code_t THR_RESET = 3'd1;

  // Receive level: request while count >= level.
  function automatic int unsigned rx_level(input thr_code_t code, input int unsigned depth);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: rx_level = ((int'(code) + 1) * depth) / 4;
      default:                rx_level = depth / 2;
    endcase
  endfunction

  // Transmit level: request while count <= level.
  function automatic int unsigned tx_level(input thr_code_t code, input int unsigned depth);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: tx_level = ((3 - int'(code)) * depth) / 4;
      default:                tx_level = depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/ufp_ring.sv
module ufp_ring #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 4,
  parameter bit OVERWRITE = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             ovw_evt
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cap;
  logic             do_push, do_pop, ovw, grow;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap   = single ? CW'(1) : CW'(DEPTH);
  assign empty = (count == '0);
  assign full  = (count >= cap);

  assign do_pop = pop && !empty && !flush;

  generate
    if (OVERWRITE) begin : g_ovw
      // Full queue: newest replaces oldest, unless a read frees a slot.
      assign do_push = push && !flush;
      assign ovw     = do_push && full && !do_pop;
    end else begin : g_drop
      // Full queue: the incoming write is lost.
      assign do_push = push && !full && !flush;
      assign ovw     = 1'b0;
    end
  endgenerate

  assign grow    = do_push && !ovw;
  assign ovw_evt = ovw;

  // Storage without reset so it maps onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push)        wr_ptr <= bump(wr_ptr);
      if (do_pop || ovw)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(grow) - CW'(do_pop);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (rst)
    single |-> count <= CW'(1)); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> empty); // R12

  generate
    if (OVERWRITE) begin : g_ast_ovw
      AST_OVW_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full); // R5
    end else begin : g_ast_drop
      AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> count == $past(count)); // R6
    end
  endgenerate

endmodule

// File: rtl/ufp_thresh.sv
module ufp_thresh
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter bit IS_RX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_we,
  input  thr_code_t     thr_in,
  input  logic          single,
  input  logic [CW-1:0] count,
  output logic          irq
);

  thr_code_t     code;
  logic [CW-1:0] lvl;

  always_ff @(posedge clk) begin
    if (rst)         code <= THR_RESET;
    else if (thr_we) code <= thr_in;
  end

  generate
    if (IS_RX) begin : g_rx
      assign lvl = CW'(rx_level(code, DEPTH));
      assign irq = single ? (count != '0) : (count >= lvl);
      AST_RX_FULL_REQ: assert property (@(posedge clk) disable iff (rst)
        (!single && count == CW'(DEPTH)) |-> irq); // R9
    end else begin : g_tx
      assign lvl = CW'(tx_level(code, DEPTH));
      assign irq = single ? (count == '0) : (count <= lvl);
      AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (rst)
        (!single && count == '0) |-> irq); // R10
    end
  endgenerate

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int TX_W  = 8,
  parameter int RX_W  = 12,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en,
  input  logic [2:0]      tx_thr_in,
  input  logic [2:0]      rx_thr_in,
  input  logic            thr_we,
  input  logic            tx_wr,
  input  logic [TX_W-1:0] tx_wr_data,
  output logic            tx_empty,
  output logic            tx_full,
  output logic            tx_irq,
  input  logic            tx_pop,
  output logic [TX_W-1:0] tx_pop_data,
  input  logic            rx_push,
  input  logic [RX_W-1:0] rx_push_data,
  input  logic            rx_rd,
  output logic [RX_W-1:0] rx_rd_data,
  output logic            rx_empty,
  output logic            rx_full,
  output logic            rx_ovr,
  input  logic            rx_ovr_clr,
  output logic            rx_irq
);

  logic          en_q, flush, single, rx_ovw, tx_ovw_unused;
  logic [CW-1:0] tx_count, rx_count;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= fifo_en;
  end

  assign flush  = (fifo_en != en_q);
  assign single = !en_q;

  ufp_ring #(.WIDTH(TX_W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_tx_ring (
    .clk(clk), .rst(rst), .flush(flush), .single(single),
    .push(tx_wr), .push_data(tx_wr_data), .pop(tx_pop),
    .head(tx_pop_data), .count(tx_count),
    .empty(tx_empty), .full(tx_full), .ovw_evt(tx_ovw_unused)
  );

  ufp_ring #(.WIDTH(RX_W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_rx_ring (
    .clk(clk), .rst(rst), .flush(flush), .single(single),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_rd),
    .head(rx_rd_data), .count(rx_count),
    .empty(rx_empty), .full(rx_full), .ovw_evt(rx_ovw)
  );

  ufp_thresh #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_thr (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_in(tx_thr_in),
    .single(single), .count(tx_count), .irq(tx_irq)
  );

  ufp_thresh #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_thr (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_in(rx_thr_in),
    .single(single), .count(rx_count), .irq(rx_irq)
  );

  // Sticky overrun: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)             rx_ovr <= 1'b0;
    else if (rx_ovw)     rx_ovr <= 1'b1;
    else if (rx_ovr_clr) rx_ovr <= 1'b0;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !rx_ovr_clr) |=> rx_ovr); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    rx_ovw |=> rx_ovr); // R5
  AST_TX_SILENT: assert property (@(posedge clk) disable iff (rst)
    !tx_ovw_unused); // R6

endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b0;
  logic [2:0]  tx_thr_in = 3'd0, rx_thr_in = 3'd0;
  logic        thr_we = 1'b0;
  logic        tx_wr = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_rd = 1'b0, rx_ovr_clr = 1'b0;
  logic [7:0]  tx_wr_data = '0;
  logic [11:0] rx_push_data = '0;
  logic        tx_empty, tx_full, tx_irq, rx_empty, rx_full, rx_ovr, rx_irq;
  logic [7:0]  tx_pop_data;
  logic [11:0] rx_rd_data;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_thr_in(tx_thr_in), .rx_thr_in(rx_thr_in),
    .thr_we(thr_we), .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_irq(tx_irq), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_rd(rx_rd), .rx_rd_data(rx_rd_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_ovr_clr(rx_ovr_clr),
    .rx_irq(rx_irq)
  );

  // Behavioural reference model
  logic [7:0]  mtx[$];
  logic [11:0] mrx[$];
  bit          m_en, m_ovr;
  logic [2:0]  m_txc, m_rxc;

  function automatic int rxlvl(input logic [2:0] c);
    return (c <= 3'd3) ? int'(c) + 1 : 2;
  endfunction
  function automatic int txlvl(input logic [2:0] c);
    return (c <= 3'd3) ? 3 - int'(c) : 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mtx.delete(); mrx.delete();
      m_en = 1'b0; m_ovr = 1'b0; m_txc = 3'd1; m_rxc = 3'd1;
    end else begin
      bit ovset;
      int cap;
      ovset = 1'b0;
      cap = m_en ? 4 : 1;
      if (fifo_en != m_en) begin
        mtx.delete(); mrx.delete();
        m_en = fifo_en;
      end else begin
        bit txw_ok, rd_ok;
        txw_ok = tx_wr && (mtx.size() < cap);
        if (tx_pop && mtx.size() > 0) void'(mtx.pop_front());
        if (txw_ok) mtx.push_back(tx_wr_data);
        rd_ok = rx_rd && (mrx.size() > 0);
        if (rx_push && mrx.size() >= cap && !rd_ok) begin
          void'(mrx.pop_front());
          mrx.push_back(rx_push_data);
          ovset = 1'b1;
        end else begin
          if (rd_ok) void'(mrx.pop_front());
          if (rx_push) mrx.push_back(rx_push_data);
        end
      end
      if (ovset) m_ovr = 1'b1;
      else if (rx_ovr_clr) m_ovr = 1'b0;
      if (thr_we) begin m_txc = tx_thr_in; m_rxc = rx_thr_in; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int cap;
      bit e_rxirq, e_txirq;
      cap = m_en ? 4 : 1;
      e_rxirq = m_en ? (mrx.size() >= rxlvl(m_rxc)) : (mrx.size() != 0);
      e_txirq = m_en ? (mtx.size() <= txlvl(m_txc)) : (mtx.size() == 0);
      chk(tx_empty === (mtx.size() == 0), m_en ? "R1 tx_empty" : "R4 tx_empty", 32'(tx_empty), 32'(mtx.size() == 0));
      chk(tx_full === (mtx.size() == cap), "R6 tx_full", 32'(tx_full), 32'(mtx.size() == cap));
      if (mtx.size() > 0) chk(tx_pop_data === mtx[0], "R1 tx head", 32'(tx_pop_data), 32'(mtx[0]));
      chk(rx_empty === (mrx.size() == 0), m_en ? "R1 rx_empty" : "R4 rx_empty", 32'(rx_empty), 32'(mrx.size() == 0));
      chk(rx_full === (mrx.size() == cap), "R5 rx_full", 32'(rx_full), 32'(mrx.size() == cap));
      if (mrx.size() > 0) chk(rx_rd_data === mrx[0], "R2 rx head", 32'(rx_rd_data), 32'(mrx[0]));
      chk(rx_ovr === m_ovr, "R7 rx_ovr", 32'(rx_ovr), 32'(m_ovr));
      chk(rx_irq === e_rxirq, "R9 rx_irq", 32'(rx_irq), 32'(e_rxirq));
      chk(tx_irq === e_txirq, "R10 tx_irq", 32'(tx_irq), 32'(e_txirq));
    end
  end

  // One operation held across exactly one rising edge, then idle.
  task automatic op(input bit txw, input logic [7:0] txd, input bit txp,
                    input bit rxp, input logic [11:0] rxd, input bit rxr, input bit clr);
    @(negedge clk);
    tx_wr = txw; tx_wr_data = txd; tx_pop = txp;
    rx_push = rxp; rx_push_data = rxd; rx_rd = rxr; rx_ovr_clr = clr;
    @(negedge clk);
    tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0; rx_ovr_clr = 0;
  endtask

  task automatic setthr(input logic [2:0] t, input logic [2:0] r);
    @(negedge clk);
    thr_we = 1; tx_thr_in = t; rx_thr_in = r;
    @(negedge clk);
    thr_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R3: reset state
    chk(tx_empty && rx_empty, "R3 empties", 32'({tx_empty, rx_empty}), 32'h3);
    chk(!rx_ovr, "R3 ovr", 32'(rx_ovr), 0);
    chk(tx_irq && !rx_irq, "R3 irqs", 32'({tx_irq, rx_irq}), 32'h2);

    // Holding-register mode
    op(1, 8'hA5, 0, 0, '0, 0, 0);
    op(1, 8'h3C, 0, 0, '0, 0, 0);
    chk(tx_full && tx_pop_data == 8'hA5, "R6 dropped write", 32'(tx_pop_data), 32'hA5);
    op(0, '0, 1, 0, '0, 0, 0);
    op(0, '0, 1, 0, '0, 0, 0);
    chk(tx_empty, "R12 pop on empty", 32'(tx_empty), 1);
    op(0, '0, 0, 1, 12'h1A5, 0, 0);
    op(0, '0, 0, 1, 12'hF3C, 0, 0);
    chk(rx_rd_data == 12'hF3C && rx_ovr, "R5 overwrite", 32'(rx_rd_data), 32'hF3C);
    op(0, '0, 0, 0, '0, 0, 1);
    chk(!rx_ovr, "R7 clear", 32'(rx_ovr), 0);
    op(0, '0, 0, 1, 12'h111, 0, 0);

    // Mode change flushes, overrun preserved
    @(negedge clk); fifo_en = 1;
    @(negedge clk);
    chk(rx_empty && rx_ovr, "R8 flush", 32'({rx_empty, rx_ovr}), 32'h3);
    op(0, '0, 0, 0, '0, 0, 1);

    // Queue mode, default half thresholds
    op(0, '0, 0, 1, 12'h801, 0, 0);
    chk(!rx_irq, "R3 rx default level one entry", 32'(rx_irq), 0);
    op(0, '0, 0, 1, 12'h402, 0, 0);
    chk(rx_irq, "R9 rx at half", 32'(rx_irq), 1);
    setthr(3'd1, 3'd2);
    chk(!rx_irq, "R11 rx code 2", 32'(rx_irq), 0);
    setthr(3'd1, 3'd7);
    chk(rx_irq, "R11 reserved code", 32'(rx_irq), 1);
    for (int i = 0; i < 3; i++) op(1, 8'(8'h10 + i), 0, 0, '0, 0, 0);
    chk(!tx_irq, "R10 tx above half", 32'(tx_irq), 0);
    for (int i = 0; i < 2; i++) op(1, 8'(8'h20 + i), 0, 0, '0, 0, 0);
    chk(tx_full && tx_pop_data == 8'h10, "R1 full order", 32'(tx_pop_data), 32'h10);
    for (int i = 0; i < 4; i++) op(0, '0, 1, 0, '0, 0, 0);
    chk(tx_empty, "R1 drained", 32'(tx_empty), 1);

    // Randomised traffic checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tx_wr = ($urandom_range(0, 2) != 0); tx_wr_data = 8'($urandom);
      tx_pop = ($urandom_range(0, 2) == 0);
      rx_push = ($urandom_range(0, 2) != 0); rx_push_data = 12'($urandom);
      rx_rd = ($urandom_range(0, 2) == 0);
      rx_ovr_clr = ($urandom_range(0, 15) == 0);
      thr_we = ($urandom_range(0, 31) == 0);
      tx_thr_in = 3'($urandom); rx_thr_in = 3'($urandom);
      if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
    end
    @(negedge clk);
    tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0; rx_ovr_clr = 0; thr_we = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule